// File: doc/BRIEF.md
# Byte-Wide Host Port for a 24-Bit Position Counter

This block connects an 8-bit microprocessor bus to a 24-bit up/down position counter. The counter itself sits outside the block. Four host signals (an active-low enable, a command/data select, and active-low read and write strobes) are decoded into four kinds of access: data read, data write, status read and command write. Each strobe assertion produces one access. All bus inputs are sampled on the system clock.

Command bytes carry a two-bit class in their top bits. One class picks the target register and byte lane, and can also request a counter load or a counter snapshot. The other three classes set the index-input mode, the clear timing and edge evaluation, and the interrupt enable. A byte pointer steps through the lanes of the 24-bit target after every data byte, so a whole word moves in three consecutive accesses.

The block holds the compare word, the preload word and the snapshot (latch) word. Counter reads are served from the snapshot, so a multi-byte read stays coherent while the counter moves. Counter writes leave the block as one-cycle lane strobes.

The status byte combines two sticky flags with live inputs from the counter:
- an abnormal-input flag, which is cleared by a status read;
- a snapshot-ready flag, which is cleared by a data read.

Top module: `cnt_bus_front`

## Requirements
- R1: An access is decoded only while `bus_en_n` is 0 and exactly one of `bus_rd_n`/`bus_wr_n` is 0. With `bus_ctl`=0 a read is a data read and a write is a data write. With `bus_ctl`=1 a read is a status read and a write is a command write. With the enable high, or with both strobes low, nothing changes.
- R2: A strobe held low for several cycles performs exactly one access. The access happens in the first cycle the strobe is seen low.
- R3: A command write with bits [7:6]=00 sets the target from bits [3:2] and the byte lane from bits [1:0]:
  - target: 00 = counter, 01 = compare, 1x = preload;
  - lane: 00 = low, 01 = middle, 10 = high, 11 = low.
- R4: In a class-00 command, bit 5 drives `load_pulse` high for exactly one cycle. Bit 4 copies `cnt_value` into the snapshot word.
- R5: A data write to the compare or preload target replaces only the addressed byte. A data write to the counter target raises the `cnt_wr_strb` bit of the addressed lane for one cycle, with the byte on `cnt_wr_data`, and alters neither stored word.
- R6: After each data byte read or written, the lane advances low→middle→high→low. The target does not change.
- R7: Class 01 sets `idx_mode` from bits [1:0]. Class 10 sets `clr_sync` from bit 3, `clr_fixed` from bit 2 and `edge_mode` from bits [1:0]. Class 11 sets `irq_en` from bit 0. Fields that the command class does not own keep their values.
- R8: A data read places the addressed byte on `bus_dout` from the cycle after the strobe is first sampled. The counter target returns snapshot bytes. `bus_oe` is 1 only while enabled with the read strobe alone low.
- R9: The status byte has this layout, bit 7 to bit 0:
  - bit 7: abnormal flag;
  - bit 6: `lvl_idx`;
  - bit 5: `lvl_a`;
  - bit 4: `lvl_b`;
  - bit 3: snapshot-ready;
  - bit 2: `dir_up`;
  - bit 1: `eq_flag`;
  - bit 0: `irq_level`.
  
  A pulse on `abn_evt` sets the abnormal flag. A status read clears it, unless a new event arrives in the same cycle.
- R10: A snapshot sets the ready flag. Any data byte read clears it.
- R11: After reset:
  - the target is counter low;
  - `idx_mode`=01;
  - `clr_fixed`=1;
  - `clr_sync`=0;
  - `edge_mode`=00;
  - `irq_en`=0;
  - both flags are 0;
  - `load_pulse` and `cnt_wr_strb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_en_n | input | 1 | Active-low bus enable |
| bus_ctl | input | 1 | 1 = command/status, 0 = data |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_din | input | 8 | Byte from host |
| bus_dout | output | 8 | Byte to host |
| bus_oe | output | 1 | Drive enable for the host data bus |
| cnt_value | input | 24 | Live counter value |
| abn_evt | input | 1 | Abnormal input transition event |
| lvl_idx | input | 1 | Index input level |
| lvl_a | input | 1 | A input level |
| lvl_b | input | 1 | B input level |
| dir_up | input | 1 | Last count direction, 1 = up |
| eq_flag | input | 1 | Counter equals compare word |
| irq_level | input | 1 | Interrupt output state |
| load_pulse | output | 1 | Load preload into counter |
| cnt_wr_strb | output | 3 | Per-lane counter write strobe |
| cnt_wr_data | output | 8 | Byte for counter write |
| cmp_word | output | 24 | Compare word |
| pre_word | output | 24 | Preload word |
| idx_mode | output | 2 | Index input mode |
| clr_sync | output | 1 | 1 = synchronous clear |
| clr_fixed | output | 1 | 1 = fixed clear edge |
| edge_mode | output | 2 | Edge evaluation mode |
| irq_en | output | 1 | Interrupt enable |

## Verification
A byte pointer that is one lane off corrupts every following data access. The next read returns a neighbouring byte, or a write lands in the wrong lane of the compare or preload word, and the error is visible on `bus_dout` or on the stored words within one access. A stuck or wrongly cleared status flag shows on the very next status read. An access decoded twice from one held strobe shows up as a skipped byte on the following read. The bench walks several register/lane sequences, including wraps and a reserved lane code, so a single wrong pointer state surfaces within two accesses.

// File: rtl/cnt_bus_pkg.sv
package cnt_bus_pkg;

  typedef enum logic [2:0] {
    BOP_IDLE = 3'd0,
    BOP_DRD  = 3'd1,
    BOP_DWR  = 3'd2,
    BOP_SRD  = 3'd3,
    BOP_CWR  = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    TGT_CNT = 2'd0,
    TGT_CMP = 2'd1,
    TGT_PRE = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    CID_ACCESS = 2'd0,
    CID_INDEX  = 2'd1,
    CID_EDGE   = 2'd2,
    CID_IRQ    = 2'd3
  } cmd_id_e;

  // Map the two target select bits of an access command to a register
  function automatic tgt_e decode_tgt(input logic [1:0] f);
    if (f[1])      return TGT_PRE;
    else if (f[0]) return TGT_CMP;
    else           return TGT_CNT;
  endfunction

  // Classify one access from the strobe levels at its start
  function automatic bus_op_e classify(input logic ctl, input logic is_read);
    if (is_read) return ctl ? BOP_SRD : BOP_DRD;
    else         return ctl ? BOP_CWR : BOP_DWR;
  endfunction

  // Pack flags and live levels into the status byte
  function automatic logic [7:0] pack_status(
    input logic ai, input logic zl, input logic al, input logic bl,
    input logic rdy, input logic up, input logic eq, input logic irq);
    return {ai, zl, al, bl, rdy, up, eq, irq};
  endfunction

endpackage

// File: rtl/cnt_bus_strobe.sv
module cnt_bus_strobe
  import cnt_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_n,
  input  logic    ctl,
  input  logic    rd_n,
  input  logic    wr_n,
  output bus_op_e op_start,
  output logic    rd_active
);

  logic rd_prev_n;
  logic wr_prev_n;
  logic one_strobe;
  logic rd_fall;
  logic wr_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_n <= 1'b1;
      wr_prev_n <= 1'b1;
    end else begin
      rd_prev_n <= rd_n;
      wr_prev_n <= wr_n;
    end
  end

  assign one_strobe = !en_n && (rd_n ^ wr_n);
  assign rd_fall    = !rd_n && rd_prev_n;
  assign wr_fall    = !wr_n && wr_prev_n;

  always_comb begin
    op_start = BOP_IDLE;
    if (one_strobe) begin
      if (rd_fall)      op_start = classify(ctl, 1'b1);
      else if (wr_fall) op_start = classify(ctl, 1'b0);
    end
  end

  assign rd_active = !en_n && !rd_n && wr_n;

endmodule

// File: rtl/cnt_bus_cmd.sv
module cnt_bus_cmd
  import cnt_bus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int LANE_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_e           op,
  input  logic [DATA_W-1:0] din,
  output tgt_e              tgt,
  output logic [LANE_W-1:0] lane,
  output logic              load_pulse,
  output logic              latch_req,
  output logic [1:0]        idx_mode,
  output logic              clr_sync,
  output logic              clr_fixed,
  output logic [1:0]        edge_mode,
  output logic              irq_en
);

  cmd_id_e cid;
  logic    is_cmd;
  logic    is_data;

  function automatic logic [LANE_W-1:0] next_lane(input logic [LANE_W-1:0] l);
    if (l >= LANE_W'(NUM_BYTES - 1)) return '0;
    else                             return l + 1'b1;
  endfunction

  function automatic logic [LANE_W-1:0] lane_of_code(input logic [1:0] code);
    if (int'(code) >= NUM_BYTES) return '0;
    else                         return LANE_W'(code);
  endfunction

  assign cid     = cmd_id_e'(din[7:6]);
  assign is_cmd  = (op == BOP_CWR);
  assign is_data = (op == BOP_DRD) || (op == BOP_DWR);

  // Register target and byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt  <= TGT_CNT;
      lane <= '0;
    end else if (is_cmd && cid == CID_ACCESS) begin
      tgt  <= decode_tgt(din[3:2]);
      lane <= lane_of_code(din[1:0]);
    end else if (is_data) begin
      lane <= next_lane(lane);
    end
  end

  // Load request pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_pulse <= 1'b0;
    else        load_pulse <= is_cmd && cid == CID_ACCESS && din[5];
  end

  assign latch_req = is_cmd && cid == CID_ACCESS && din[4];

  // Mode fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_mode  <= 2'b01;
      clr_sync  <= 1'b0;
      clr_fixed <= 1'b1;
      edge_mode <= 2'b00;
      irq_en    <= 1'b0;
    end else if (is_cmd) begin
      case (cid)
        CID_INDEX: idx_mode <= din[1:0];
        CID_EDGE: begin
          clr_sync  <= din[3];
          clr_fixed <= din[2];
          edge_mode <= din[1:0];
        end
        CID_IRQ:  irq_en <= din[0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/cnt_bus_regs.sv
module cnt_bus_regs
  import cnt_bus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int LANE_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int WORD_W   = DATA_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_op_e              op,
  input  logic [DATA_W-1:0]    din,
  input  tgt_e                 tgt,
  input  logic [LANE_W-1:0]    lane,
  input  logic                 latch_req,
  input  logic [WORD_W-1:0]    cnt_value,
  output logic [WORD_W-1:0]    cmp_word,
  output logic [WORD_W-1:0]    pre_word,
  output logic [NUM_BYTES-1:0] cnt_wr_strb,
  output logic [DATA_W-1:0]    cnt_wr_data,
  output logic [DATA_W-1:0]    rd_byte
);

  logic [WORD_W-1:0]    lat_word;
  logic [NUM_BYTES-1:0] lane_hit;
  logic                 wr_op;

  function automatic logic [DATA_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                input logic [LANE_W-1:0] l);
    return w[int'(l)*DATA_W +: DATA_W];
  endfunction

  assign wr_op = (op == BOP_DWR);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lane_hit[g] = (lane == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_word[g*DATA_W +: DATA_W] <= '0;
        pre_word[g*DATA_W +: DATA_W] <= '0;
      end else if (wr_op && lane_hit[g]) begin
        if (tgt == TGT_CMP) cmp_word[g*DATA_W +: DATA_W] <= din;
        if (tgt == TGT_PRE) pre_word[g*DATA_W +: DATA_W] <= din;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_wr_strb[g] <= 1'b0;
      else        cnt_wr_strb[g] <= wr_op && lane_hit[g] && tgt == TGT_CNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_wr_data <= '0;
    else if (wr_op && tgt == TGT_CNT)    cnt_wr_data <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_word <= '0;
    else if (latch_req) lat_word <= cnt_value;
  end

  always_comb begin
    case (tgt)
      TGT_CMP: rd_byte = byte_of(cmp_word, lane);
      TGT_PRE: rd_byte = byte_of(pre_word, lane);
      default: rd_byte = byte_of(lat_word, lane);
    endcase
  end

endmodule

// File: rtl/cnt_bus_status.sv
module cnt_bus_status
  import cnt_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_op_e op,
  input  logic    latch_req,
  input  logic    abn_evt,
  input  logic    lvl_idx,
  input  logic    lvl_a,
  input  logic    lvl_b,
  input  logic    dir_up,
  input  logic    eq_flag,
  input  logic    irq_level,
  output logic    ai_flag,
  output logic    dtr_flag,
  output logic [7:0] stat_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ai_flag <= 1'b0;
    else if (abn_evt)        ai_flag <= 1'b1;
    else if (op == BOP_SRD)  ai_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dtr_flag <= 1'b0;
    else if (latch_req)      dtr_flag <= 1'b1;
    else if (op == BOP_DRD)  dtr_flag <= 1'b0;
  end

  assign stat_byte = pack_status(ai_flag, lvl_idx, lvl_a, lvl_b,
                                 dtr_flag, dir_up, eq_flag, irq_level);

endmodule

// File: rtl/cnt_bus_front.sv
module cnt_bus_front
  import cnt_bus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int WORD_W   = DATA_W * NUM_BYTES,
  localparam int LANE_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en_n,
  input  logic                 bus_ctl,
  input  logic                 bus_rd_n,
  input  logic                 bus_wr_n,
  input  logic [DATA_W-1:0]    bus_din,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_oe,
  input  logic [WORD_W-1:0]    cnt_value,
  input  logic                 abn_evt,
  input  logic                 lvl_idx,
  input  logic                 lvl_a,
  input  logic                 lvl_b,
  input  logic                 dir_up,
  input  logic                 eq_flag,
  input  logic                 irq_level,
  output logic                 load_pulse,
  output logic [NUM_BYTES-1:0] cnt_wr_strb,
  output logic [DATA_W-1:0]    cnt_wr_data,
  output logic [WORD_W-1:0]    cmp_word,
  output logic [WORD_W-1:0]    pre_word,
  output logic [1:0]           idx_mode,
  output logic                 clr_sync,
  output logic                 clr_fixed,
  output logic [1:0]           edge_mode,
  output logic                 irq_en
);

  bus_op_e           op;
  tgt_e              tgt;
  logic [LANE_W-1:0] lane;
  logic              latch_req;
  logic              ai_flag;
  logic              dtr_flag;
  logic [7:0]        stat_byte;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] rd_buf;

  // Named events for the checker
  logic op_drd, op_dwr, op_srd, op_cwr;
  assign op_drd = (op == BOP_DRD);
  assign op_dwr = (op == BOP_DWR);
  assign op_srd = (op == BOP_SRD);
  assign op_cwr = (op == BOP_CWR);

  cnt_bus_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_n      (bus_en_n),
    .ctl       (bus_ctl),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .op_start  (op),
    .rd_active (bus_oe)
  );

  cnt_bus_cmd #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .din        (bus_din),
    .tgt        (tgt),
    .lane       (lane),
    .load_pulse (load_pulse),
    .latch_req  (latch_req),
    .idx_mode   (idx_mode),
    .clr_sync   (clr_sync),
    .clr_fixed  (clr_fixed),
    .edge_mode  (edge_mode),
    .irq_en     (irq_en)
  );

  cnt_bus_regs #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .din         (bus_din),
    .tgt         (tgt),
    .lane        (lane),
    .latch_req   (latch_req),
    .cnt_value   (cnt_value),
    .cmp_word    (cmp_word),
    .pre_word    (pre_word),
    .cnt_wr_strb (cnt_wr_strb),
    .cnt_wr_data (cnt_wr_data),
    .rd_byte     (rd_byte)
  );

  cnt_bus_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .latch_req (latch_req),
    .abn_evt   (abn_evt),
    .lvl_idx   (lvl_idx),
    .lvl_a     (lvl_a),
    .lvl_b     (lvl_b),
    .dir_up    (dir_up),
    .eq_flag   (eq_flag),
    .irq_level (irq_level),
    .ai_flag   (ai_flag),
    .dtr_flag  (dtr_flag),
    .stat_byte (stat_byte)
  );

  // Read buffer: captured at the start of each read access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_buf <= '0;
    else if (op_drd) rd_buf <= rd_byte;
    else if (op_srd) rd_buf <= stat_byte[DATA_W-1:0];
  end

  assign bus_dout = rd_buf;

endmodule

// File: rtl/cnt_bus_front_chk.sv
module cnt_bus_front_chk #(
  parameter int NUM_BYTES = 3,
  localparam int LANE_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en_n,
  input logic                 op_drd,
  input logic                 op_dwr,
  input logic                 op_srd,
  input logic                 op_cwr,
  input logic [LANE_W-1:0]    lane,
  input logic                 load_pulse,
  input logic [NUM_BYTES-1:0] cnt_wr_strb,
  input logic                 abn_evt,
  input logic                 ai_flag,
  input logic                 dtr_flag,
  input logic [1:0]           idx_mode,
  input logic                 clr_sync,
  input logic                 clr_fixed,
  input logic [1:0]           edge_mode,
  input logic                 irq_en
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_n |-> !(op_drd || op_dwr || op_srd || op_cwr)); // R1

  AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_drd || op_dwr) && lane == LANE_W'(NUM_BYTES - 1)) |=> lane == '0); // R6

  AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_drd || op_dwr) && lane < LANE_W'(NUM_BYTES - 1)) |=> lane == $past(lane) + 1'b1); // R6

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R4

  AST_WR_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr_strb)); // R5

  AST_AI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    abn_evt |=> ai_flag); // R9

  AST_AI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_srd && !abn_evt) |=> !ai_flag); // R9

  AST_DTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_drd |=> !dtr_flag); // R10

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_cwr |=> $stable({idx_mode, clr_sync, clr_fixed, edge_mode, irq_en})); // R7

endmodule

bind cnt_bus_front cnt_bus_front_chk #(.NUM_BYTES(NUM_BYTES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en_n    (bus_en_n),
  .op_drd      (op_drd),
  .op_dwr      (op_dwr),
  .op_srd      (op_srd),
  .op_cwr      (op_cwr),
  .lane        (lane),
  .load_pulse  (load_pulse),
  .cnt_wr_strb (cnt_wr_strb),
  .abn_evt     (abn_evt),
  .ai_flag     (ai_flag),
  .dtr_flag    (dtr_flag),
  .idx_mode    (idx_mode),
  .clr_sync    (clr_sync),
  .clr_fixed   (clr_fixed),
  .edge_mode   (edge_mode),
  .irq_en      (irq_en)
);

// File: tb/cnt_bus_front_tb.sv
`timescale 1ns/100ps
module cnt_bus_front_tb_top;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en_n = 1'b1, bus_ctl = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [23:0] cnt_value = '0;
  logic        abn_evt = 1'b0, lvl_idx = 1'b0, lvl_a = 1'b0, lvl_b = 1'b0;
  logic        dir_up = 1'b0, eq_flag = 1'b0, irq_level = 1'b0;
  logic        load_pulse;
  logic [2:0]  cnt_wr_strb;
  logic [7:0]  cnt_wr_data;
  logic [23:0] cmp_word, pre_word;
  logic [1:0]  idx_mode, edge_mode;
  logic        clr_sync, clr_fixed, irq_en;

  int n_chk = 0;
  int n_bad = 0;
  int load_cnt = 0;
  logic [2:0] last_strb = '0;
  logic [7:0] last_data = '0;
  logic       oe_seen;

  always #(HALF) clk = ~clk;

  cnt_bus_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_ctl(bus_ctl),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .cnt_value(cnt_value),
    .abn_evt(abn_evt), .lvl_idx(lvl_idx), .lvl_a(lvl_a), .lvl_b(lvl_b),
    .dir_up(dir_up), .eq_flag(eq_flag), .irq_level(irq_level),
    .load_pulse(load_pulse), .cnt_wr_strb(cnt_wr_strb), .cnt_wr_data(cnt_wr_data),
    .cmp_word(cmp_word), .pre_word(pre_word), .idx_mode(idx_mode),
    .clr_sync(clr_sync), .clr_fixed(clr_fixed), .edge_mode(edge_mode),
    .irq_en(irq_en)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (load_pulse) load_cnt++;
    if (|cnt_wr_strb) begin
      last_strb = cnt_wr_strb;
      last_data = cnt_wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 command write, 1 data write, 2 data read, 3 status read
  task automatic bus_op(input int kind, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_en_n = 1'b0;
    bus_ctl  = (kind == 0 || kind == 3);
    bus_din  = d;
    if (kind >= 2) bus_rd_n = 1'b0;
    else           bus_wr_n = 1'b0;
    @(negedge clk);
    q       = bus_dout;
    oe_seen = bus_oe;
    bus_rd_n = 1'b1;
    bus_wr_n = 1'b1;
    bus_en_n = 1'b1;
    @(negedge clk);
  endtask

  // {kind[1:0], din[7:0], expected[7:0]}
  localparam int NV = 21;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h04, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00},
    {2'd1, 8'h33, 8'h00}, {2'd2, 8'h00, 8'h11}, {2'd2, 8'h00, 8'h22},
    {2'd2, 8'h00, 8'h33}, {2'd2, 8'h00, 8'h11}, {2'd0, 8'h09, 8'h00},
    {2'd1, 8'h55, 8'h00}, {2'd1, 8'h66, 8'h00}, {2'd1, 8'h44, 8'h00},
    {2'd0, 8'h08, 8'h00}, {2'd2, 8'h00, 8'h44}, {2'd2, 8'h00, 8'h55},
    {2'd2, 8'h00, 8'h66}, {2'd0, 8'h06, 8'h00}, {2'd2, 8'h00, 8'h33},
    {2'd2, 8'h00, 8'h11}, {2'd0, 8'h0F, 8'h00}, {2'd2, 8'h00, 8'h44}
  };

  initial begin
    #(HALF * 2 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int lc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 idx_mode", idx_mode, 2'b01);
    check("R11 clr_fixed", clr_fixed, 1'b1);
    check("R11 clr_sync", clr_sync, 1'b0);
    check("R11 edge_mode", edge_mode, 2'b00);
    check("R11 irq_en", irq_en, 1'b0);
    check("R11 strobes", {load_pulse, cnt_wr_strb, bus_oe}, 5'b0);
    bus_op(3, 8'h00, q);
    check("R11 status after reset", q, 8'h00);

    // R9 live levels in status layout
    lvl_idx = 1; lvl_a = 0; lvl_b = 1; dir_up = 1; eq_flag = 0; irq_level = 1;
    bus_op(3, 8'h00, q);
    check("R9 status levels", q, 8'h55);
    check("R8 oe off on status? no, on during read", oe_seen, 1'b1);

    // R3 R5 R6 R8 table walk
    for (int i = 0; i < NV; i++) begin
      bus_op(int'(VEC[i][17:16]), VEC[i][15:8], q);
      if (VEC[i][17:16] == 2'd2) begin
        check($sformatf("R6 R8 vector %0d", i), q, VEC[i][7:0]);
        check($sformatf("R8 oe vector %0d", i), oe_seen, 1'b1);
      end
    end
    check("R5 compare word", cmp_word, 24'h332211);
    check("R5 preload word", pre_word, 24'h665544);

    // R4 R10 snapshot and coherent reads
    cnt_value = 24'hABCDEF;
    bus_op(0, 8'h10, q);
    bus_op(3, 8'h00, q);
    check("R10 ready set", q, 8'h5D);
    cnt_value = 24'h123456;
    bus_op(2, 8'h00, q);
    check("R8 snapshot low", q, 8'hEF);
    bus_op(3, 8'h00, q);
    check("R10 ready cleared", q, 8'h55);
    bus_op(2, 8'h00, q);
    check("R8 snapshot mid", q, 8'hCD);
    bus_op(2, 8'h00, q);
    check("R8 snapshot high", q, 8'hAB);

    // R4 load pulse
    lc = load_cnt;
    bus_op(0, 8'h20, q);
    check("R4 one load pulse", load_cnt - lc, 1);

    // R5 counter lane writes
    bus_op(0, 8'h01, q);
    bus_op(1, 8'h9A, q);
    check("R5 counter mid strobe", {last_strb, last_data}, {3'b010, 8'h9A});
    bus_op(1, 8'h7B, q);
    check("R5 counter high strobe", {last_strb, last_data}, {3'b100, 8'h7B});
    check("R5 stored words untouched", {cmp_word, pre_word}, {24'h332211, 24'h665544});

    // R1 disabled bus and dual strobes ignored
    @(negedge clk);
    bus_en_n = 1; bus_ctl = 1; bus_wr_n = 0; bus_din = 8'hC1;
    repeat (2) @(negedge clk);
    bus_wr_n = 1;
    @(negedge clk);
    check("R1 disabled write ignored", irq_en, 1'b0);
    bus_rd_n = 0;
    @(negedge clk);
    check("R1 oe off when disabled", bus_oe, 1'b0);
    bus_rd_n = 1;
    @(negedge clk);
    bus_en_n = 0; bus_rd_n = 0; bus_wr_n = 0;
    repeat (2) @(negedge clk);
    bus_en_n = 1; bus_rd_n = 1; bus_wr_n = 1;
    @(negedge clk);
    check("R1 dual strobes ignored", irq_en, 1'b0);

    // R7 mode commands
    bus_op(0, 8'hC1, q);
    check("R7 irq enable", irq_en, 1'b1);
    bus_op(0, 8'h8E, q);
    check("R7 edge fields", {clr_sync, clr_fixed, edge_mode, idx_mode}, {1'b1, 1'b1, 2'b10, 2'b01});
    bus_op(0, 8'h43, q);
    check("R7 index field", {idx_mode, edge_mode, irq_en}, {2'b11, 2'b10, 1'b1});
    bus_op(0, 8'h80, q);
    check("R7 edge cleared", {clr_sync, clr_fixed, edge_mode}, 4'b0000);

    // R2 held read strobe performs one access
    bus_op(0, 8'h04, q);
    @(negedge clk);
    bus_en_n = 0; bus_ctl = 0; bus_rd_n = 0;
    repeat (3) @(negedge clk);
    check("R2 held read first byte", bus_dout, 8'h11);
    bus_rd_n = 1; bus_en_n = 1;
    @(negedge clk);
    bus_op(2, 8'h00, q);
    check("R2 single advance", q, 8'h22);

    // R9 abnormal flag sticky then cleared by status read
    @(negedge clk);
    abn_evt = 1;
    @(negedge clk);
    abn_evt = 0;
    bus_op(3, 8'h00, q);
    check("R9 abnormal set", q, 8'hD5);
    bus_op(3, 8'h00, q);
    check("R9 abnormal cleared", q, 8'h55);

    // R11 reset mid-run restores defaults
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 defaults again", {idx_mode, clr_fixed, irq_en}, {2'b01, 1'b1, 1'b0});
    bus_op(2, 8'h00, q);
    check("R11 pointer counter low", q, 8'h00);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule